// File: doc/BRIEF.md
# Dual-Bus Memory Window Decoder

This block sits between two processor cores and their on-chip memories. Each core has a data port and an instruction port. Each port carries requests made of an address, an access size and a valid signal. The block classifies every accepted request and returns three things one cycle later:

- a one-hot vector naming the target memory,
- the physical word index inside that target,
- an error flag.

The error flag covers bad sizes, alignment faults, addresses owned by the other bus, reserved holes, and regions that are disabled or not open to that core.

The address map gives the block its particular work:

- One 128 KB SRAM is seen from the instruction side in reversed word order.
- A 32 KB boot window at the bottom of the instruction space can be steered to a slice of that SRAM, separately for each core. While steered, the slice's normal instruction alias is closed.
- A small fast retention memory answers only core 0.
- The lower 64 KB of another SRAM disappears from the instruction map while it is lent out as cache.
- External windows are only recognised and tagged with an offset.

Every lane is an independent valid/ready stage. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the lane's result register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the result holds and new requests wait.

Top module: `memwin_decoder`

## Requirements
- R1: After reset every `rsp_valid` bit is 0 and every `req_ready` bit is 1.
- R2: Lane l (lane 2c is core c's data port, lane 2c+1 is its instruction port) accepts when `req_valid[l]` and `req_ready[l]` are both high. `req_ready[l]` equals `!rsp_valid[l] || rsp_ready[l]`. The result shows on the outputs at the next rising edge and holds unchanged while `rsp_valid[l]` is high and `rsp_ready[l]` is low.
- R3: A data port may address only below 0x4000_0000 or from 0x5000_0000 up. An instruction port may address only from 0x4000_0000 up. Any other request returns an error.
- R4: Size codes are 0 = byte, 1 = half-word, 2 = word; code 3 is always an error. Instruction ports accept only word size with address bits [1:0] equal to 0. Data ports accept any alignment, and the index is that of the word holding the first byte.
- R5: Target bits are: 0 internal ROM, 1 data-only ROM, 2 SRAM0, 3 SRAM1, 4 SRAM2, 5 fast retention RAM, 6 slow retention RAM, 7 peripheral window, 8 external flash, 9 external RAM. A good result has exactly one bit set. An error has all target bits clear and index 0.
- R6: Data map (index = (address − low bound) >> 2):
  - 0x3F40_0000–0x3F7F_FFFF is external flash.
  - 0x3F80_0000–0x3FBF_FFFF is external RAM.
  - 0x3FF0_0000–0x3FF7_FFFF is the peripheral window.
  - 0x3FF9_0000–0x3FF9_FFFF is the data-only ROM.
  - 0x3FFA_E000–0x3FFD_FFFF is SRAM2.
  - 0x3FFE_0000–0x3FFF_FFFF is SRAM1.
- R7: Instruction map:
  - 0x4000_0000–0x4005_FFFF is internal ROM, index (a − 0x4000_0000) >> 2.
  - 0x4008_0000–0x4009_FFFF is SRAM0, index (a − 0x4007_0000) >> 2.
  - 0x400C_2000–0x40BF_FFFF is external flash, index (a − 0x400C_2000) >> 2.
- R8: Instruction addresses 0x400A_0000–0x400B_FFFF reach SRAM1 in reversed word order, with index 0x7FFF − ((a − 0x400A_0000) >> 2). Byte lanes inside a word keep their order.
- R9: When `remap_en[c]` is 1, core c's instruction addresses 0x4000_0000–0x4000_7FFF reach SRAM1 with index 0x3FFF − ((a − 0x4000_0000) >> 2). In that state core c's instruction addresses 0x400B_0000–0x400B_7FFF return an error, and its data alias 0x3FFE_8000–0x3FFE_FFFF still works. The other core is unaffected.
- R10: Core 0 reaches the fast retention RAM at data 0x3FF8_0000–0x3FF8_1FFF and at instruction 0x400C_0000–0x400C_1FFF, with the same index (offset >> 2) from both windows. Core 1 gets an error in both windows.
- R11: When `sram0_low_cached` is 1, instruction addresses 0x4007_0000–0x4007_FFFF return an error. When it is 0, they reach SRAM0 with index (a − 0x4007_0000) >> 2.
- R12: Addresses 0x5000_0000–0x5000_1FFF reach the slow retention RAM from every port of both cores, with index (a − 0x5000_0000) >> 2.
- R13: These reserved holes return an error:
  - below 0x3F40_0000,
  - 0x3FC0_0000–0x3FEF_FFFF,
  - 0x3FF8_2000–0x3FF8_FFFF,
  - 0x3FFA_0000–0x3FFA_DFFF,
  - 0x4006_0000–0x4006_FFFF,
  - 0x40C0_0000–0x4FFF_FFFF,
  - from 0x5000_2000 up.
- R14: A request is decoded with the `remap_en` and `sram0_low_cached` values present in its accept cycle, including a value that changed in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 2*N_CORES | Request valid per lane |
| req_ready | output | 2*N_CORES | Request ready per lane |
| req_addr | input | 2*N_CORES x 32 | Byte address per lane |
| req_size | input | 2*N_CORES x 2 | Access size code per lane |
| remap_en | input | N_CORES | Boot-window steering enable per core |
| sram0_low_cached | input | 1 | Lower SRAM0 64 KB lent to cache |
| rsp_valid | output | 2*N_CORES | Result valid per lane |
| rsp_ready | input | 2*N_CORES | Result taken per lane |
| rsp_target | output | 2*N_CORES x 10 | One-hot target per lane |
| rsp_index | output | 2*N_CORES x IDX_W | Word index into target per lane |
| rsp_err | output | 2*N_CORES | Error flag per lane |

## Verification
Two things can fall in the same cycle and need care.

The first is a change of a core's steering bit landing in the very cycle that both cores' instruction ports present the boot address. The bench flips `remap_en` on the same falling edge that raises both requests. It then expects each core's result to follow its own new bit: one lane lands in SRAM1 at index 0x3FFF while the other lands in ROM at index 0.

The second is a stalled result meeting a fresh request on the same lane. The bench holds `rsp_ready` low with a second request waiting. It checks that the first result stays put and `req_ready` stays low, then checks that the second request is taken in the cycle `rsp_ready` returns.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

  localparam int NUM_TGT = 10;
  localparam int SEL_W   = $clog2(NUM_TGT + 1);

  localparam int T_IROM  = 0;
  localparam int T_DROM  = 1;
  localparam int T_SRAM0 = 2;
  localparam int T_SRAM1 = 3;
  localparam int T_SRAM2 = 4;
  localparam int T_FAST  = 5;
  localparam int T_SLOW  = 6;
  localparam int T_PERI  = 7;
  localparam int T_XFL   = 8;
  localparam int T_XRAM  = 9;
  localparam logic [SEL_W-1:0] SEL_NONE = SEL_W'(NUM_TGT);

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_BAD  = 2'd3;

  // bus ownership
  localparam logic [31:0] INSTR_BASE  = 32'h4000_0000;
  localparam logic [31:0] SHARED_BASE = 32'h5000_0000;

  // shared window
  localparam logic [31:0] SLOW_LO = 32'h5000_0000;
  localparam logic [31:0] SLOW_HI = 32'h5000_1FFF;

  // data side windows
  localparam logic [31:0] DXFL_LO  = 32'h3F40_0000;
  localparam logic [31:0] DXFL_HI  = 32'h3F7F_FFFF;
  localparam logic [31:0] DXRAM_LO = 32'h3F80_0000;
  localparam logic [31:0] DXRAM_HI = 32'h3FBF_FFFF;
  localparam logic [31:0] PERI_LO  = 32'h3FF0_0000;
  localparam logic [31:0] PERI_HI  = 32'h3FF7_FFFF;
  localparam logic [31:0] DFAST_LO = 32'h3FF8_0000;
  localparam logic [31:0] DFAST_HI = 32'h3FF8_1FFF;
  localparam logic [31:0] DROM_LO  = 32'h3FF9_0000;
  localparam logic [31:0] DROM_HI  = 32'h3FF9_FFFF;
  localparam logic [31:0] SRAM2_LO = 32'h3FFA_E000;
  localparam logic [31:0] SRAM2_HI = 32'h3FFD_FFFF;
  localparam logic [31:0] DS1_LO   = 32'h3FFE_0000;
  localparam logic [31:0] DS1_HI   = 32'h3FFF_FFFF;

  // instruction side windows
  localparam logic [31:0] BOOT_HI   = 32'h4000_7FFF;
  localparam logic [31:0] IROM_HI   = 32'h4005_FFFF;
  localparam logic [31:0] IS0_LO    = 32'h4007_0000;
  localparam logic [31:0] IS0_CCH   = 32'h4007_FFFF;
  localparam logic [31:0] IS0_HI    = 32'h4009_FFFF;
  localparam logic [31:0] IS1_LO    = 32'h400A_0000;
  localparam logic [31:0] IS1_HI    = 32'h400B_FFFF;
  localparam logic [31:0] IS1_TOPW  = 32'h400B_FFFC;
  localparam logic [31:0] ALIAS_LO  = 32'h400B_0000;
  localparam logic [31:0] ALIAS_HI  = 32'h400B_7FFF;
  localparam logic [31:0] IFAST_LO  = 32'h400C_0000;
  localparam logic [31:0] IFAST_HI  = 32'h400C_1FFF;
  localparam logic [31:0] IXFL_LO   = 32'h400C_2000;
  localparam logic [31:0] IXFL_HI   = 32'h40BF_FFFF;
  localparam logic [31:0] BOOT_SHIFT = ALIAS_LO - INSTR_BASE;

  function automatic logic in_win(input logic [31:0] a, input logic [31:0] lo,
                                  input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/memwin_match.sv
module memwin_match
  import memwin_pkg::*;
#(
  parameter bit IS_INSTR  = 1'b0,
  parameter bit OWNS_FAST = 1'b1,
  parameter int IDX_W     = 22
) (
  input  logic [31:0]        addr,
  input  logic [1:0]         size,
  input  logic               remap,
  input  logic               cached,
  output logic [NUM_TGT-1:0] tgt,
  output logic [IDX_W-1:0]   idx,
  output logic               err
);

  logic [SEL_W-1:0] bus_sel;
  logic [31:0]      bus_off;
  logic [SEL_W-1:0] sel;
  logic [31:0]      off;
  logic             fault;

  // size and alignment screening
  always_comb begin
    fault = (size == SZ_BAD);
    if (IS_INSTR && ((size != SZ_WORD) || (addr[1:0] != 2'b00))) fault = 1'b1;
  end

  generate
    if (IS_INSTR) begin : g_instr
      always_comb begin
        bus_sel = SEL_NONE;
        bus_off = '0;
        if (addr < INSTR_BASE) begin
          bus_sel = SEL_NONE;
        end else if (remap && (addr <= BOOT_HI)) begin
          bus_sel = SEL_W'(T_SRAM1);
          bus_off = IS1_TOPW - (addr + BOOT_SHIFT);
        end else if (addr <= IROM_HI) begin
          bus_sel = SEL_W'(T_IROM);
          bus_off = addr - INSTR_BASE;
        end else if (in_win(addr, IS0_LO, IS0_HI)) begin
          if (!(cached && (addr <= IS0_CCH))) begin
            bus_sel = SEL_W'(T_SRAM0);
            bus_off = addr - IS0_LO;
          end
        end else if (in_win(addr, IS1_LO, IS1_HI)) begin
          if (!(remap && in_win(addr, ALIAS_LO, ALIAS_HI))) begin
            bus_sel = SEL_W'(T_SRAM1);
            bus_off = IS1_TOPW - addr;
          end
        end else if (in_win(addr, IFAST_LO, IFAST_HI)) begin
          if (OWNS_FAST) begin
            bus_sel = SEL_W'(T_FAST);
            bus_off = addr - IFAST_LO;
          end
        end else if (in_win(addr, IXFL_LO, IXFL_HI)) begin
          bus_sel = SEL_W'(T_XFL);
          bus_off = addr - IXFL_LO;
        end
      end
    end else begin : g_data
      always_comb begin
        bus_sel = SEL_NONE;
        bus_off = '0;
        if (addr >= INSTR_BASE) begin
          bus_sel = SEL_NONE;
        end else if (in_win(addr, DXFL_LO, DXFL_HI)) begin
          bus_sel = SEL_W'(T_XFL);
          bus_off = addr - DXFL_LO;
        end else if (in_win(addr, DXRAM_LO, DXRAM_HI)) begin
          bus_sel = SEL_W'(T_XRAM);
          bus_off = addr - DXRAM_LO;
        end else if (in_win(addr, PERI_LO, PERI_HI)) begin
          bus_sel = SEL_W'(T_PERI);
          bus_off = addr - PERI_LO;
        end else if (in_win(addr, DFAST_LO, DFAST_HI)) begin
          if (OWNS_FAST) begin
            bus_sel = SEL_W'(T_FAST);
            bus_off = addr - DFAST_LO;
          end
        end else if (in_win(addr, DROM_LO, DROM_HI)) begin
          bus_sel = SEL_W'(T_DROM);
          bus_off = addr - DROM_LO;
        end else if (in_win(addr, SRAM2_LO, SRAM2_HI)) begin
          bus_sel = SEL_W'(T_SRAM2);
          bus_off = addr - SRAM2_LO;
        end else if (in_win(addr, DS1_LO, DS1_HI)) begin
          bus_sel = SEL_W'(T_SRAM1);
          bus_off = addr - DS1_LO;
        end
      end
    end
  endgenerate

  // shared window overrides the per-bus decode
  always_comb begin
    sel = bus_sel;
    off = bus_off;
    if (addr >= SHARED_BASE) begin
      sel = SEL_NONE;
      off = '0;
      if (addr <= SLOW_HI) begin
        sel = SEL_W'(T_SLOW);
        off = addr - SLOW_LO;
      end
    end
  end

  always_comb begin
    err = fault || (sel == SEL_NONE);
    idx = err ? '0 : off[IDX_W+1:2];
    for (int i = 0; i < NUM_TGT; i++) tgt[i] = !err && (sel == SEL_W'(i));
  end

endmodule

// File: rtl/memwin_lane.sv
module memwin_lane
  import memwin_pkg::*;
#(
  parameter bit IS_INSTR  = 1'b0,
  parameter bit OWNS_FAST = 1'b1,
  parameter int IDX_W     = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_addr,
  input  logic [1:0]         in_size,
  input  logic               remap,
  input  logic               cached,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [NUM_TGT-1:0] out_tgt,
  output logic [IDX_W-1:0]   out_idx,
  output logic               out_err
);

  logic [NUM_TGT-1:0] d_tgt;
  logic [IDX_W-1:0]   d_idx;
  logic               d_err;
  logic               take;

  memwin_match #(
    .IS_INSTR (IS_INSTR),
    .OWNS_FAST(OWNS_FAST),
    .IDX_W    (IDX_W)
  ) u_match (
    .addr  (in_addr),
    .size  (in_size),
    .remap (remap),
    .cached(cached),
    .tgt   (d_tgt),
    .idx   (d_idx),
    .err   (d_err)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_tgt   <= '0;
      out_idx   <= '0;
      out_err   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_tgt   <= d_tgt;
      out_idx   <= d_idx;
      out_err   <= d_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/memwin_decoder.sv
module memwin_decoder
  import memwin_pkg::*;
#(
  parameter int N_CORES    = 2,
  parameter int FAST_OWNER = 0,
  parameter int IDX_W      = 22,
  localparam int NL        = 2 * N_CORES
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NL-1:0]                 req_valid,
  output logic [NL-1:0]                 req_ready,
  input  logic [NL-1:0][31:0]           req_addr,
  input  logic [NL-1:0][1:0]            req_size,
  input  logic [N_CORES-1:0]            remap_en,
  input  logic                          sram0_low_cached,
  output logic [NL-1:0]                 rsp_valid,
  input  logic [NL-1:0]                 rsp_ready,
  output logic [NL-1:0][NUM_TGT-1:0]    rsp_target,
  output logic [NL-1:0][IDX_W-1:0]      rsp_index,
  output logic [NL-1:0]                 rsp_err
);

  for (genvar l = 0; l < NL; l++) begin : g_lane
    localparam int CORE = l / 2;
    memwin_lane #(
      .IS_INSTR (l % 2 == 1),
      .OWNS_FAST(CORE == FAST_OWNER),
      .IDX_W    (IDX_W)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (req_valid[l]),
      .in_ready (req_ready[l]),
      .in_addr  (req_addr[l]),
      .in_size  (req_size[l]),
      .remap    (remap_en[CORE]),
      .cached   (sram0_low_cached),
      .out_valid(rsp_valid[l]),
      .out_ready(rsp_ready[l]),
      .out_tgt  (rsp_target[l]),
      .out_idx  (rsp_index[l]),
      .out_err  (rsp_err[l])
    );
  end

endmodule

module memwin_decoder_chk
  import memwin_pkg::*;
#(
  parameter int N_CORES    = 2,
  parameter int FAST_OWNER = 0,
  parameter int IDX_W      = 22,
  localparam int NL        = 2 * N_CORES
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NL-1:0]              req_valid,
  input logic [NL-1:0]              req_ready,
  input logic [NL-1:0][31:0]        req_addr,
  input logic [NL-1:0]              rsp_valid,
  input logic [NL-1:0]              rsp_ready,
  input logic [NL-1:0][NUM_TGT-1:0] rsp_target,
  input logic [NL-1:0][IDX_W-1:0]   rsp_index,
  input logic [NL-1:0]              rsp_err
);

  for (genvar l = 0; l < NL; l++) begin : g_chk
    // R5
    good_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid[l] && !rsp_err[l]) |-> ($countones(rsp_target[l]) == 1));
    // R5
    err_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid[l] && rsp_err[l]) |-> (rsp_target[l] == '0 && rsp_index[l] == '0));
    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid[l] && !rsp_ready[l]) |=> (rsp_valid[l] && $stable(rsp_target[l])
        && $stable(rsp_index[l]) && $stable(rsp_err[l])));
    // R2
    ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[l] == (!rsp_valid[l] || rsp_ready[l]));
    if (l % 2 == 1) begin : g_ins
      // R4
      ins_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[l] && req_ready[l] && req_addr[l][1:0] != 2'b00) |=>
          (rsp_valid[l] && rsp_err[l]));
    end else begin : g_dat
      // R3
      data_no_instr_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid[l] |-> (!rsp_target[l][T_IROM] && !rsp_target[l][T_SRAM0]));
    end
    if (l / 2 != FAST_OWNER) begin : g_nofast
      // R10
      fast_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid[l] |-> !rsp_target[l][T_FAST]);
    end
  end

endmodule

bind memwin_decoder memwin_decoder_chk #(
  .N_CORES   (N_CORES),
  .FAST_OWNER(FAST_OWNER),
  .IDX_W     (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_target(rsp_target),
  .rsp_index (rsp_index),
  .rsp_err   (rsp_err)
);

// File: tb/memwin_decoder_test.sv
module memwin_decoder_test;

  localparam int NC = 2;
  localparam int NL = 2 * NC;
  localparam int IW = 22;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NL-1:0]        req_valid = '0;
  logic [NL-1:0]        req_ready;
  logic [NL-1:0][31:0]  req_addr = '0;
  logic [NL-1:0][1:0]   req_size = '0;
  logic [NC-1:0]        remap_en = '0;
  logic                 sram0_low_cached = 1'b0;
  logic [NL-1:0]        rsp_valid;
  logic [NL-1:0]        rsp_ready = '1;
  logic [NL-1:0][9:0]   rsp_target;
  logic [NL-1:0][IW-1:0] rsp_index;
  logic [NL-1:0]        rsp_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  memwin_decoder #(.N_CORES(NC), .FAST_OWNER(0), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size),
    .remap_en(remap_en), .sram0_low_cached(sram0_low_cached),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_target(rsp_target), .rsp_index(rsp_index), .rsp_err(rsp_err)
  );

  // independent arithmetic model of the address map
  function automatic void model(input int l, input logic [31:0] a, input logic [1:0] sz,
                                input bit rm, input bit cc, output logic [9:0] t,
                                output logic [IW-1:0] x, output bit e, output string tag);
    bit ins = (l % 2) == 1;
    bit c0  = (l / 2) == 0;
    int tb = -1;
    logic [31:0] off = 0;
    tag = "R13";
    if (sz == 2'd3) tag = "R4";
    else if (ins && (sz != 2'd2 || a[1:0] != 2'b00)) tag = "R4";
    else if (a >= 32'h5000_0000) begin
      tag = "R12";
      if (a < 32'h5000_2000) begin tb = 6; off = (a - 32'h5000_0000) / 4; end
      else tag = "R13";
    end else if (ins != (a >= 32'h4000_0000)) tag = "R3";
    else if (ins) begin
      if (rm && a < 32'h4000_8000) begin tag = "R9"; tb = 3; off = 32'h3FFF - (a - 32'h4000_0000) / 4; end
      else if (a < 32'h4006_0000) begin tag = "R7"; tb = 0; off = (a - 32'h4000_0000) / 4; end
      else if (a < 32'h4007_0000) tag = "R13";
      else if (a < 32'h4008_0000) begin tag = "R11"; if (!cc) begin tb = 2; off = (a - 32'h4007_0000) / 4; end end
      else if (a < 32'h400A_0000) begin tag = "R7"; tb = 2; off = (a - 32'h4007_0000) / 4; end
      else if (a < 32'h400C_0000) begin
        tag = "R8";
        if (rm && a >= 32'h400B_0000 && a < 32'h400B_8000) tag = "R9";
        else begin tb = 3; off = 32'h7FFF - (a - 32'h400A_0000) / 4; end
      end
      else if (a < 32'h400C_2000) begin tag = "R10"; if (c0) begin tb = 5; off = (a - 32'h400C_0000) / 4; end end
      else if (a < 32'h40C0_0000) begin tag = "R7"; tb = 8; off = (a - 32'h400C_2000) / 4; end
    end else begin
      if (a < 32'h3F40_0000) tag = "R13";
      else if (a < 32'h3F80_0000) begin tag = "R6"; tb = 8; off = (a - 32'h3F40_0000) / 4; end
      else if (a < 32'h3FC0_0000) begin tag = "R6"; tb = 9; off = (a - 32'h3F80_0000) / 4; end
      else if (a < 32'h3FF0_0000) tag = "R13";
      else if (a < 32'h3FF8_0000) begin tag = "R6"; tb = 7; off = (a - 32'h3FF0_0000) / 4; end
      else if (a < 32'h3FF8_2000) begin tag = "R10"; if (c0) begin tb = 5; off = (a - 32'h3FF8_0000) / 4; end end
      else if (a < 32'h3FF9_0000) tag = "R13";
      else if (a < 32'h3FFA_0000) begin tag = "R6"; tb = 1; off = (a - 32'h3FF9_0000) / 4; end
      else if (a < 32'h3FFA_E000) tag = "R13";
      else if (a < 32'h3FFE_0000) begin tag = "R6"; tb = 4; off = (a - 32'h3FFA_E000) / 4; end
      else begin tag = "R6"; tb = 3; off = (a - 32'h3FFE_0000) / 4; end
    end
    e = (tb < 0);
    t = e ? 10'd0 : (10'd1 << tb);
    x = e ? '0 : off[IW-1:0];
  endfunction

  task automatic check_lane(input int l, input logic [9:0] et, input logic [IW-1:0] ex,
                            input bit ee, input string tag);
    checks++;
    if (rsp_valid[l] !== 1'b1 || rsp_target[l] !== et || rsp_index[l] !== ex || rsp_err[l] !== ee) begin
      errors++;
      $display("FAIL %s lane %0d addr %h: got v=%b t=%b i=%h e=%b, expected v=1 t=%b i=%h e=%b",
               tag, l, req_addr[l], rsp_valid[l], rsp_target[l], rsp_index[l], rsp_err[l],
               et, ex, ee);
    end
  endtask

  task automatic issue(input int l, input logic [31:0] a, input logic [1:0] sz);
    @(negedge clk);
    req_valid    = '0;
    req_valid[l] = 1'b1;
    req_addr[l]  = a;
    req_size[l]  = sz;
    @(negedge clk);
    req_valid[l] = 1'b0;
  endtask

  task automatic issue_and_model(input int l, input logic [31:0] a, input logic [1:0] sz);
    logic [9:0] et; logic [IW-1:0] ex; bit ee; string tg;
    model(l, a, sz, remap_en[l / 2], sram0_low_cached, et, ex, ee, tg);
    issue(l, a, sz);
    check_lane(l, et, ex, ee, tg);
  endtask

  logic [31:0] pts [49] = '{
    32'h0000_0000, 32'h3F3F_FFFC, 32'h3F40_0000, 32'h3F7F_FFFC, 32'h3F80_0000,
    32'h3FBF_FFFC, 32'h3FC0_0000, 32'h3FEF_FFFC, 32'h3FF0_0000, 32'h3FF7_FFFC,
    32'h3FF8_0000, 32'h3FF8_1FFC, 32'h3FF8_2000, 32'h3FF8_FFFC, 32'h3FF9_0000,
    32'h3FF9_FFFC, 32'h3FFA_0000, 32'h3FFA_DFFC, 32'h3FFA_E000, 32'h3FFD_FFFC,
    32'h3FFE_0000, 32'h3FFE_8000, 32'h3FFF_FFFC, 32'h4000_0000, 32'h4000_7FFC,
    32'h4000_8000, 32'h4005_FFFC, 32'h4006_0000, 32'h4006_FFFC, 32'h4007_0000,
    32'h4007_FFFC, 32'h4008_0000, 32'h4009_FFFC, 32'h400A_0000, 32'h400A_FFFC,
    32'h400B_0000, 32'h400B_7FFC, 32'h400B_8000, 32'h400B_FFFC, 32'h400C_0000,
    32'h400C_1FFC, 32'h400C_2000, 32'h40BF_FFFC, 32'h40C0_0000, 32'h4FFF_FFFC,
    32'h5000_0000, 32'h5000_1FFC, 32'h5000_2000, 32'hFFFF_FFFC
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (rsp_valid !== '0 || req_ready !== '1) begin
      errors++;
      $display("FAIL R1 reset: got rsp_valid=%b req_ready=%b, expected 0000 1111", rsp_valid, req_ready);
    end
    rst_n = 1'b1;

    // explicit spot checks
    issue(0, 32'h3FFE_0000, 2'd0);
    check_lane(0, 10'b00_0000_1000, 22'h0, 0, "R8 data base");
    issue(1, 32'h400B_FFFC, 2'd2);
    check_lane(1, 10'b00_0000_1000, 22'h0, 0, "R8 reversed top");
    issue(1, 32'h400A_0000, 2'd2);
    check_lane(1, 10'b00_0000_1000, 22'h7FFF, 0, "R8 reversed bottom");
    issue(0, 32'h3FC0_0000, 2'd2);
    check_lane(0, 10'd0, 22'h0, 1, "R5 error blanks target");
    issue(2, 32'h5000_0010, 2'd2);
    check_lane(2, 10'b00_0100_0000, 22'h4, 0, "R5 one-hot slow");
    issue(3, 32'h5000_0008, 2'd2);
    check_lane(3, 10'b00_0100_0000, 22'h2, 0, "R12 core1 instr");
    issue(0, 32'h3FFA_E003, 2'd0);
    check_lane(0, 10'b00_0001_0000, 22'h0, 0, "R4 data unaligned byte");
    issue(1, 32'h4000_0002, 2'd2);
    check_lane(1, 10'd0, 22'h0, 1, "R4 instr misaligned");
    issue(1, 32'h3FFE_0000, 2'd2);
    check_lane(1, 10'd0, 22'h0, 1, "R3 instr port on data space");

    // R9 per-core steering
    remap_en = 2'b01;
    issue(1, 32'h400B_0000, 2'd2);
    check_lane(1, 10'd0, 22'h0, 1, "R9 alias closed");
    issue(0, 32'h3FFE_8000, 2'd2);
    check_lane(0, 10'b00_0000_1000, 22'h2000, 0, "R9 data alias open");
    issue(3, 32'h400B_0000, 2'd2);
    check_lane(3, 10'b00_0000_1000, 22'h3FFF, 0, "R9 other core alias open");
    remap_en = 2'b00;

    // R14 steering change in the accept cycle, both cores at once
    @(negedge clk);
    remap_en = 2'b01;
    req_valid = 4'b1010;
    req_addr[1] = 32'h4000_0000; req_size[1] = 2'd2;
    req_addr[3] = 32'h4000_0000; req_size[3] = 2'd2;
    @(negedge clk);
    check_lane(1, 10'b00_0000_1000, 22'h3FFF, 0, "R14 core0 steered");
    check_lane(3, 10'b00_0000_0001, 22'h0, 0, "R14 core1 rom");
    remap_en = 2'b10;
    @(negedge clk);
    req_valid = '0;
    check_lane(1, 10'b00_0000_0001, 22'h0, 0, "R14 core0 rom");
    check_lane(3, 10'b00_0000_1000, 22'h3FFF, 0, "R14 core1 steered");
    remap_en = 2'b00;
    @(negedge clk);
    sram0_low_cached = 1'b1;
    req_valid[1] = 1'b1; req_addr[1] = 32'h4007_0000;
    @(negedge clk);
    req_valid = '0;
    sram0_low_cached = 1'b0;
    check_lane(1, 10'd0, 22'h0, 1, "R14 cache flag same cycle");

    // R2 back-pressure
    @(negedge clk);
    rsp_ready[0] = 1'b0;
    req_valid[0] = 1'b1; req_addr[0] = 32'h3FF9_0010; req_size[0] = 2'd2;
    @(negedge clk);
    req_addr[0] = 32'h3FF0_0020;
    checks++;
    if (req_ready[0] !== 1'b0) begin
      errors++;
      $display("FAIL R2 ready under stall: got %b, expected 0", req_ready[0]);
    end
    @(negedge clk);
    check_lane(0, 10'b00_0000_0010, 22'h4, 0, "R2 held result");
    rsp_ready[0] = 1'b1;
    @(negedge clk);
    req_valid[0] = 1'b0;
    check_lane(0, 10'b00_1000_0000, 22'h8, 0, "R2 waiting request taken");
    @(negedge clk);

    // sweep over lanes, settings, boundary points and sizes
    for (int l = 0; l < NL; l++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        remap_en = (cfg[0]) ? 2'b11 : 2'b00;
        sram0_low_cached = cfg[1];
        for (int p = 0; p < 49; p++) begin
          issue_and_model(l, pts[p], 2'd2);
          issue_and_model(l, pts[p] + 32'd1, 2'd0);
          issue_and_model(l, pts[p] + 32'd2, 2'd1);
          issue_and_model(l, pts[p] + 32'd3, 2'd2);
          issue_and_model(l, pts[p], 2'd3);
        end
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule